// File: doc/BRIEF.md
# Unrolled Circular CORDIC Rotator

This block rotates a two-dimensional vector by a given angle. It uses a chain of shift-and-add micro-rotations that contains no registers. Each stage of the chain has its own fixed right shift and its own constant arctangent. These are fixed when the design elaborates, so neither a shifter nor an angle table is needed. The angle arrives in radians as a signed fixed-point value. At each stage the sign of the remaining angle decides whether the stage turns the vector forwards or backwards.

The rotated coordinates come out still multiplied by the chain gain G, the product of sqrt(1 + 2^-2i) over all stages, which is about 1.6468. The remaining angle is also available as an output. To obtain cosine and sine, drive X with round(2^13 / G), which is 4975, drive Y with zero, and apply the angle. The X output then carries the cosine and the Y output carries the sine, both in the same fixed-point format as the angle.

Top module: `cordic_rotator`

## Requirements
- R1: Number format. The angle input and all coordinates are two's-complement values with 13 fractional bits, so 1.0 is the code 8192. The angle is in radians. With x_in = 4975, y_in = 0 and z_in anywhere in [-12868, 12868] (±pi/2), x_out is within 4 LSB of 4975·G·cos(z_in/8192) and y_out is within 4 LSB of 4975·G·sin(z_in/8192).
- R2: For |x_in|, |y_in| ≤ 8192 and z_in in ±pi/2, x_out is within 4 LSB of G·(x·cos z − y·sin z) and y_out is within 4 LSB of G·(y·cos z + x·sin z).
- R3: For z_in in [-12868, 12868], the residual angle z_out lies in [-1, 1]. No stage increases the magnitude of the remaining angle beyond the larger of its incoming magnitude and that stage's constant.
- R4: The outputs depend only on the present inputs. They settle without any clock edge, and the same input vector always gives the same outputs whatever was applied before.
- R5: When a rotated coordinate exceeds the 16-bit range, it clamps to 32767 or -32768 with the correct sign. It never wraps around.
- R6: A zero input vector gives x_out = y_out = 0 exactly, for any angle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | Signed X coordinate, 13 fractional bits |
| y_in | input | 16 | Signed Y coordinate, 13 fractional bits |
| z_in | input | 16 | Signed rotation angle in radians, 13 fractional bits |
| x_out | output | 16 | Rotated X, scaled by G, saturated |
| y_out | output | 16 | Rotated Y, scaled by G, saturated |
| z_out | output | 16 | Residual angle after the last stage |

## Verification
The hardest case to reach from the ports is clamping. Within the documented input range the internal guard bits absorb all growth, so clamping never occurs there. The stimulus reaches it by driving full-scale coordinates with zero or quarter-turn angles, so that the scaled result exceeds the 16-bit range while the internal chain still has headroom. The bench also sweeps the whole ±pi/2 angle range in fine steps against a real-valued model, and covers a grid of general vectors. It checks that the outputs need no clock edge by changing the inputs between edges and sampling after a short delay.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

   localparam real PI_R = 3.14159265358979323846;

   // Rounded code of atan(2^-idx) with fbits fractional bits (series for idx>0)
   function automatic int atan_code(input int idx, input int fbits);
      real x;
      real pw;
      real acc;
      acc = 0.0;
      if (idx == 0) begin
         acc = PI_R / 4.0;
      end else begin
         x  = 1.0 / (2.0 ** idx);
         pw = x;
         for (int k = 0; k < 40; k++) begin
            if (k % 2 == 0) acc = acc + pw / (2.0 * k + 1.0);
            else            acc = acc - pw / (2.0 * k + 1.0);
            pw = pw * x * x;
         end
      end
      return $rtoi(acc * (2.0 ** fbits) + 0.5);
   endfunction

   function automatic int half_pi_code(input int fbits);
      return $rtoi(PI_R / 2.0 * (2.0 ** fbits) + 0.5);
   endfunction

endpackage

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage #(
   parameter int DW    = 22,
   parameter int AW    = 20,
   parameter int SHIFT = 0,
   parameter int ANGLE = 0
) (
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] y_i,
   input  logic signed [AW-1:0] z_i,
   output logic signed [DW-1:0] x_o,
   output logic signed [DW-1:0] y_o,
   output logic signed [AW-1:0] z_o
);

   localparam logic signed [AW-1:0] ANG = AW'(ANGLE);

   if (SHIFT < 0 || SHIFT >= DW) begin : g_bad_shift
      $error("cordic_rot_stage: SHIFT out of range");
   end
   if (ANGLE < 0 || ANGLE >= 2 ** (AW - 2)) begin : g_bad_angle
      $error("cordic_rot_stage: ANGLE does not fit");
   end

   logic signed [DW-1:0] x_sh;
   logic signed [DW-1:0] y_sh;
   logic                 turn_back;

   always_comb begin
      turn_back = z_i[AW-1];
      x_sh      = x_i >>> SHIFT;
      y_sh      = y_i >>> SHIFT;
      if (turn_back) begin
         x_o = x_i + y_sh;
         y_o = y_i - x_sh;
         z_o = z_i + ANG;
      end else begin
         x_o = x_i - y_sh;
         y_o = y_i + x_sh;
         z_o = z_i - ANG;
      end
   end

   logic signed [AW:0] zi_w;
   logic signed [AW:0] zo_w;
   logic        [AW:0] zi_mag;
   logic        [AW:0] zo_mag;

   always_comb begin
      zi_w   = (AW+1)'(z_i);
      zo_w   = (AW+1)'(z_o);
      zi_mag = zi_w[AW] ? -zi_w : zi_w;
      zo_mag = zo_w[AW] ? -zo_w : zo_w;
      // R3: the remaining angle never grows past max(|z_i|, stage constant)
      a_r3_residual_bounded: assert (zo_mag <= zi_mag || zo_mag <= (AW+1)'(ANGLE))
         else $error("a_r3_residual_bounded: stage %0d", SHIFT);
      // R6: a null vector stays null through every stage
      a_r6_null_vector_kept: assert (!(x_i == '0 && y_i == '0) || (x_o == '0 && y_o == '0))
         else $error("a_r6_null_vector_kept: stage %0d", SHIFT);
   end

endmodule

// File: rtl/cordic_rot_narrow.sv
module cordic_rot_narrow #(
   parameter int IW       = 22,
   parameter int OW       = 16,
   parameter int DROP     = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [IW-1:0] v_i,
   output logic signed [OW-1:0] v_o
);

   localparam logic signed [IW-1:0] OMAX = IW'((2 ** (OW - 1)) - 1);
   localparam logic signed [IW-1:0] OMIN = -IW'(2 ** (OW - 1));

   if (IW - DROP < OW) begin : g_bad_width
      $error("cordic_rot_narrow: IW - DROP must cover OW");
   end

   logic signed [IW-1:0] rnd;
   logic signed [IW-1:0] trunc;

   assign trunc = v_i >>> DROP;

   if (DROP > 0) begin : g_round
      assign rnd = (v_i + IW'(2 ** (DROP - 1))) >>> DROP;
   end else begin : g_pass
      assign rnd = v_i;
   end

   if (SATURATE) begin : g_clamp
      always_comb begin
         if (rnd > OMAX)      v_o = OMAX[OW-1:0];
         else if (rnd < OMIN) v_o = OMIN[OW-1:0];
         else                 v_o = rnd[OW-1:0];
      end
   end else begin : g_wrap
      assign v_o = rnd[OW-1:0];
   end

   logic signed [IW-1:0] diff;

   always_comb begin
      diff = IW'(v_o) - trunc;
      // R5: narrowing keeps the sign of the wide value
      a_r5_sign_kept: assert (v_i[IW-1] ? (v_o <= 0) : (v_o >= 0))
         else $error("a_r5_sign_kept: in %0d out %0d", v_i, v_o);
      // R5: inside the output range the result is the truncation or one above
      a_r5_in_range_exact: assert (trunc < OMIN || trunc > OMAX || diff == 0 || diff == 1)
         else $error("a_r5_in_range_exact: in %0d out %0d", v_i, v_o);
   end

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
   parameter int DATA_W     = 16,
   parameter int ANG_FRAC   = 13,
   parameter int STAGES     = 17,
   parameter int FRAC_GUARD = 4,
   parameter int INT_GUARD  = 2
) (
   input  logic signed [DATA_W-1:0] x_in,
   input  logic signed [DATA_W-1:0] y_in,
   input  logic signed [DATA_W-1:0] z_in,
   output logic signed [DATA_W-1:0] x_out,
   output logic signed [DATA_W-1:0] y_out,
   output logic signed [DATA_W-1:0] z_out
);

   localparam int IW        = DATA_W + INT_GUARD + FRAC_GUARD;
   localparam int ZW        = DATA_W + FRAC_GUARD;
   localparam int AF        = ANG_FRAC + FRAC_GUARD;
   localparam int HALF_PI_Q = cordic_rot_pkg::half_pi_code(ANG_FRAC);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("cordic_rotator: DATA_W too small");
   end
   if (ANG_FRAC < 1 || ANG_FRAC > DATA_W - 3) begin : g_bad_frac
      $error("cordic_rotator: angle needs two integer bits and a sign");
   end
   if (STAGES < 1 || STAGES > IW - 1) begin : g_bad_stages
      $error("cordic_rotator: STAGES out of range");
   end
   if (INT_GUARD < 2 || FRAC_GUARD < 0) begin : g_bad_guard
      $error("cordic_rotator: guard bits too few");
   end

   logic signed [IW-1:0] xc [0:STAGES];
   logic signed [IW-1:0] yc [0:STAGES];
   logic signed [ZW-1:0] zc [0:STAGES];

   logic signed [IW-1:0] x_wide;
   logic signed [IW-1:0] y_wide;
   logic signed [ZW-1:0] z_wide;

   assign x_wide = IW'(x_in);
   assign y_wide = IW'(y_in);
   assign z_wide = ZW'(z_in);
   assign xc[0]  = x_wide <<< FRAC_GUARD;
   assign yc[0]  = y_wide <<< FRAC_GUARD;
   assign zc[0]  = z_wide <<< FRAC_GUARD;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cordic_rot_stage #(
         .DW    (IW),
         .AW    (ZW),
         .SHIFT (i),
         .ANGLE (cordic_rot_pkg::atan_code(i, AF))
      ) u_stage (
         .x_i (xc[i]),
         .y_i (yc[i]),
         .z_i (zc[i]),
         .x_o (xc[i+1]),
         .y_o (yc[i+1]),
         .z_o (zc[i+1])
      );
   end

   cordic_rot_narrow #(.IW(IW), .OW(DATA_W), .DROP(FRAC_GUARD), .SATURATE(1'b1)) u_nx (
      .v_i (xc[STAGES]),
      .v_o (x_out)
   );
   cordic_rot_narrow #(.IW(IW), .OW(DATA_W), .DROP(FRAC_GUARD), .SATURATE(1'b1)) u_ny (
      .v_i (yc[STAGES]),
      .v_o (y_out)
   );
   cordic_rot_narrow #(.IW(ZW), .OW(DATA_W), .DROP(FRAC_GUARD), .SATURATE(1'b0)) u_nz (
      .v_i (zc[STAGES]),
      .v_o (z_out)
   );

   logic angle_ok;

   always_comb begin
      angle_ok = (int'(z_in) <= HALF_PI_Q) && (int'(z_in) >= -HALF_PI_Q);
      // R3: an in-range angle is fully consumed by the chain
      a_r3_residual_small: assert (!angle_ok || (z_out >= -1 && z_out <= 1))
         else $error("a_r3_residual_small: z_in %0d z_out %0d", z_in, z_out);
   end

endmodule

// File: tb/cordic_rotator_test.sv
module cordic_rotator_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic signed [15:0] x_in = '0;
   logic signed [15:0] y_in = '0;
   logic signed [15:0] z_in = '0;
   logic signed [15:0] x_out;
   logic signed [15:0] y_out;
   logic signed [15:0] z_out;

   cordic_rotator uut (
      .x_in  (x_in),
      .y_in  (y_in),
      .z_in  (z_in),
      .x_out (x_out),
      .y_out (y_out),
      .z_out (z_out)
   );

   int  n_vec  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;
   real gain   = 1.0;
   localparam int KINV = 4975;
   localparam int HP   = 12868;

   task automatic chk(input string req, input string what, input int act, input real exp, input real tol);
      real d;
      n_vec++;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0.3f", req, what, act, exp);
      end
   endtask

   task automatic drive(input int x, input int y, input int z);
      @(posedge clk);
      #2;
      x_in = 16'(x);
      y_in = 16'(y);
      z_in = 16'(z);
      @(negedge clk);
   endtask

   task automatic rot_check(input string req, input int x, input int y, input int z);
      real th;
      drive(x, y, z);
      th = real'(z) / 8192.0;
      chk(req, "x", int'(x_out), gain * (x * $cos(th) - y * $sin(th)), 4.0);
      chk(req, "y", int'(y_out), gain * (y * $cos(th) + x * $sin(th)), 4.0);
      chk("R3", "z residual", int'(z_out), 0.0, 1.0);
   endtask

   initial begin
      int ax, ay, az;
      int gx [7] = '{-8192, -5000, -1234, 0, 777, 4096, 8191};
      int gz [7] = '{-12868, -6000, -1, 0, 2500, 9999, 12868};
      for (int i = 0; i < 17; i++) gain = gain * $sqrt(1.0 + 1.0 / (4.0 ** i));

      // initial state: all-zero inputs give zero outputs (R6)
      @(negedge clk);
      chk("R6", "x at start", int'(x_out), 0.0, 0.0);
      chk("R6", "y at start", int'(y_out), 0.0, 0.0);

      // R1: sine/cosine sweep over the full angle range
      for (int t = -HP; t <= HP; t += 13) rot_check("R1", KINV, 0, t);
      rot_check("R1", KINV, 0, HP);
      rot_check("R1", KINV, 0, -HP);
      rot_check("R1", KINV, 0, 0);

      // R2: general vectors over a grid of angles
      for (int a = 0; a < 7; a++)
         for (int b = 0; b < 7; b++)
            for (int c = 0; c < 7; c++) rot_check("R2", gx[a], gx[b], gz[c]);

      // R4: settle between edges, history-free
      drive(3000, -2000, 4000);
      ax = int'(x_out); ay = int'(y_out); az = int'(z_out);
      drive(-7000, 6000, -11000);
      #3;
      x_in = 16'(3000); y_in = -16'(2000); z_in = 16'(4000);
      #1;
      chk("R4", "x no clock", int'(x_out), real'(ax), 0.0);
      chk("R4", "y no clock", int'(y_out), real'(ay), 0.0);
      chk("R4", "z no clock", int'(z_out), real'(az), 0.0);

      // R5: clamping of out-of-range results
      drive(32767, 32767, 0);
      chk("R5", "x pos clamp", int'(x_out), 32767.0, 0.0);
      chk("R5", "y pos clamp", int'(y_out), 32767.0, 0.0);
      drive(-32768, -32768, 0);
      chk("R5", "x neg clamp", int'(x_out), -32768.0, 0.0);
      chk("R5", "y neg clamp", int'(y_out), -32768.0, 0.0);
      drive(32767, -32767, 0);
      chk("R5", "x pos clamp mix", int'(x_out), 32767.0, 0.0);
      chk("R5", "y neg clamp mix", int'(y_out), -32768.0, 0.0);
      drive(32767, 0, HP);
      chk("R5", "x near zero", int'(x_out), 0.0, 4.0);
      chk("R5", "y clamp at quarter turn", int'(y_out), 32767.0, 0.0);

      // R6: null vector for several angles
      for (int k = -3; k <= 3; k++) begin
         drive(0, 0, k * 4000);
         chk("R6", "x null", int'(x_out), 0.0, 0.0);
         chk("R6", "y null", int'(y_out), 0.0, 0.0);
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule